// File: doc/BRIEF.md
# Baseband I/Q Input Formatter

This block sits at the entry of a transmit interpolation chain. It takes a 12-bit parallel data bus and a single framing strobe and turns them into time-aligned pairs of 12-bit I and Q samples. Each pair appears on the outputs together with a one-cycle valid pulse. The bus carries one beat per clock. Each sample is either one whole 12-bit beat, or it is packed from narrower beats on the top bits of the bus.

The strobe means different things in the two timing modes. In burst timing it frames a run of data. Its rising edge aligns the block, and while it stays high the completed samples alternate I, Q, I, Q. In continuous timing the strobe level names the current beat: high means the beat is I and low means it is Q. Continuous timing is legal only with full-word beats. If it is requested with a narrow format, an error flag is raised and the block runs in burst timing instead. Configuration is static and comes from a register file.

Top module: `iq_input_formatter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pair_valid` is 0 and `pair_i` and `pair_q` are 0.
- R2: Burst timing with full-word format (`cfg_width` = 2'b00). The beat taken on a rising strobe edge is an I sample. While the strobe stays high, beats alternate I and Q. `pair_valid` pulses in the cycle after the clock edge that samples the Q beat, and that cycle carries the I and Q samples.
- R3: Half-word format (`cfg_width` = 2'b01). Each sample is built from two beats on bus bits [11:6], most significant part first. Bus bits [5:0] are ignored.
- R4: Quarter-word format (`cfg_width` = 2'b10). Each sample is built from four beats on bus bits [11:9], most significant part first. Bus bits [8:0] are ignored.
- R5: In burst timing, dropping the strobe discards any partly assembled sample and any I sample still waiting for its Q. No pair is emitted for that data.
- R6: Every rising strobe edge restarts assembly. The first beat after the edge begins a new I sample.
- R7: Continuous timing (`cfg_continuous` = 1 with full-word format). A beat with the strobe high is stored as I and replaces any earlier stored I. A beat with the strobe low is Q. It emits a pair with the stored I and then clears it. A Q beat with no stored I is dropped.
- R8: If `cfg_continuous` = 1 while the format is half or quarter word, `cfg_error` is 1 and the block behaves as in burst timing. Otherwise `cfg_error` is 0.
- R9: `pair_valid` is never high on two consecutive cycles. `pair_i` and `pair_q` hold their values between pulses.
- R10: The width code 2'b11 behaves exactly as full-word format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Beat format: 00 full, 01 half, 10 quarter, 11 full |
| cfg_continuous | input | 1 | Request continuous timing |
| bus_data | input | 12 | Parallel input data beat |
| strobe | input | 1 | Burst frame, or I/Q selector in continuous timing |
| pair_valid | output | 1 | One-cycle pulse marking a new I/Q pair |
| pair_i | output | 12 | I sample of the latest pair |
| pair_q | output | 12 | Q sample of the latest pair |
| cfg_error | output | 1 | Continuous timing requested with a narrow format |

## Verification
Full-word bursts of even and odd length check the I/Q alternation and show that a trailing lone I is dropped. Half-word and quarter-word bursts carry random junk in the unused low bus bits, which shows both the most-significant-first packing and that those bits are ignored. A burst cut off partway through a sample, followed by a new rising edge, separates correct resynchronisation from stale partial data leaking into the next pair. Continuous sequences with repeated highs, repeated lows and a leading low check the rules for replacing I and dropping Q, and a continuous request with a half-word format checks the error fallback.

// File: rtl/iqf_pkg.sv
package iqf_pkg;

    typedef enum logic [1:0] {
        WM_FULL    = 2'b00,
        WM_HALF    = 2'b01,
        WM_QUARTER = 2'b10,
        WM_ALIAS   = 2'b11
    } width_mode_e;

endpackage

// File: rtl/iqf_mode_decode.sv
module iqf_mode_decode
    import iqf_pkg::*;
(
    input  logic [1:0]  width_code,
    input  logic        cont_req,
    output width_mode_e mode_eff,
    output logic [1:0]  last_beat,
    output logic        cont_eff,
    output logic        cfg_err
);

    always_comb begin
        unique case (width_code)
            2'b01:   begin mode_eff = WM_HALF;    last_beat = 2'd1; end
            2'b10:   begin mode_eff = WM_QUARTER; last_beat = 2'd3; end
            default: begin mode_eff = WM_FULL;    last_beat = 2'd0; end
        endcase
        cont_eff = cont_req && (mode_eff == WM_FULL);
        cfg_err  = cont_req && (mode_eff != WM_FULL);
    end

endmodule

// File: rtl/iqf_strobe_sync.sv
module iqf_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);

    logic strobe_d, strobe_q;

    always_comb begin
        strobe_d = strobe;
        rise     = strobe && !strobe_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_d;
    end

endmodule

// File: rtl/iqf_word_packer.sv
module iqf_word_packer
    import iqf_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  width_mode_e       mode,
    input  logic [1:0]        last_beat,
    input  logic              beat_valid,
    input  logic              restart,
    input  logic              flush,
    input  logic [DATA_W-1:0] bus,
    output logic              word_done,
    output logic [DATA_W-1:0] word
);

    localparam int HALF_W = DATA_W / 2;
    localparam int QTR_W  = DATA_W / 4;

    typedef struct packed {
        logic [1:0]        cnt;
        logic [DATA_W-1:0] acc;
    } pack_t;

    pack_t st_d, st_q;
    logic [1:0]        cnt_eff;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        cnt_eff = restart ? 2'd0 : st_q.cnt;
        unique case (mode)
            WM_HALF:    shifted = {st_q.acc[DATA_W-HALF_W-1:0], bus[DATA_W-1 -: HALF_W]};
            WM_QUARTER: shifted = {st_q.acc[DATA_W-QTR_W-1:0],  bus[DATA_W-1 -: QTR_W]};
            default:    shifted = bus;
        endcase
        word      = shifted;
        word_done = beat_valid && (cnt_eff >= last_beat);
        if (flush) begin
            st_d.cnt = 2'd0;
        end else if (beat_valid) begin
            st_d.acc = shifted;
            st_d.cnt = word_done ? 2'd0 : cnt_eff + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/iq_input_formatter.sv
module iq_input_formatter
    import iqf_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_continuous,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              strobe,
    output logic              pair_valid,
    output logic [DATA_W-1:0] pair_i,
    output logic [DATA_W-1:0] pair_q,
    output logic              cfg_error
);

    typedef struct packed {
        logic              have_i;
        logic [DATA_W-1:0] i_hold;
        logic              valid;
        logic [DATA_W-1:0] out_i;
        logic [DATA_W-1:0] out_q;
    } pair_t;

    width_mode_e       mode_eff;
    logic [1:0]        last_beat;
    logic              cont_eff;
    logic              rise;
    logic              word_done;
    logic [DATA_W-1:0] word;
    logic              have_i_eff;
    pair_t             st_d, st_q;

    iqf_mode_decode u_mode (
        .width_code (cfg_width),
        .cont_req   (cfg_continuous),
        .mode_eff   (mode_eff),
        .last_beat  (last_beat),
        .cont_eff   (cont_eff),
        .cfg_err    (cfg_error)
    );

    iqf_strobe_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (rise)
    );

    iqf_word_packer #(.DATA_W(DATA_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_eff),
        .last_beat  (last_beat),
        .beat_valid (strobe && !cont_eff),
        .restart    (rise),
        .flush      (!strobe || cont_eff),
        .bus        (bus_data),
        .word_done  (word_done),
        .word       (word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        have_i_eff = rise ? 1'b0 : st_q.have_i;
        if (!cont_eff) begin
            if (!strobe) begin
                st_d.have_i = 1'b0;
            end else if (word_done) begin
                if (!have_i_eff) begin
                    st_d.i_hold = word;
                    st_d.have_i = 1'b1;
                end else begin
                    st_d.out_i  = st_q.i_hold;
                    st_d.out_q  = word;
                    st_d.valid  = 1'b1;
                    st_d.have_i = 1'b0;
                end
            end else begin
                st_d.have_i = have_i_eff;
            end
        end else begin
            if (strobe) begin
                st_d.i_hold = bus_data;
                st_d.have_i = 1'b1;
            end else if (st_q.have_i) begin
                st_d.out_i  = st_q.i_hold;
                st_d.out_q  = bus_data;
                st_d.valid  = 1'b1;
                st_d.have_i = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_valid = st_q.valid;
    assign pair_i     = st_q.out_i;
    assign pair_q     = st_q.out_q;

    // R9
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R9
    hold_between_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(pair_i) && $stable(pair_q)));

    // R5
    burst_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !$past(cont_eff)) |-> $past(strobe));

    // R7
    cont_pair_on_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && $past(cont_eff)) |-> !$past(strobe));

endmodule

// File: tb/iq_input_formatter_tb.sv
`timescale 1ns/1ps
module iq_input_formatter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_width;
    logic        cfg_continuous;
    logic [11:0] bus_data;
    logic        strobe;
    logic        pair_valid;
    logic [11:0] pair_i, pair_q;
    logic        cfg_error;

    always #2.5 clk = ~clk;

    iq_input_formatter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_width      (cfg_width),
        .cfg_continuous (cfg_continuous),
        .bus_data       (bus_data),
        .strobe         (strobe),
        .pair_valid     (pair_valid),
        .pair_i         (pair_i),
        .pair_q         (pair_q),
        .cfg_error      (cfg_error)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string tag   = "R1";

    logic        m_prev, m_have, e_v;
    logic [11:0] m_ihold, e_i, e_q;
    int          subq[$];

    task automatic chk(input string t, input string what, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic ee;
        ee = cfg_continuous && (cfg_width == 2'b01 || cfg_width == 2'b10);
        chk(tag, "pair_valid", {11'd0, pair_valid}, {11'd0, e_v});
        chk(tag, "pair_i", pair_i, e_i);
        chk(tag, "pair_q", pair_q, e_q);
        chk((ee ? "R8" : tag), "cfg_error", {11'd0, cfg_error}, {11'd0, ee});
    endtask

    task automatic model_step(input logic s, input logic [11:0] d);
        int  bc;
        int  sw;
        int  w;
        bit  c;
        bc = (cfg_width == 2'b01) ? 2 : (cfg_width == 2'b10) ? 4 : 1;
        sw = 12 / bc;
        c  = cfg_continuous && (bc == 1);
        e_v = 1'b0;
        if (!c) begin
            if (s) begin
                if (!m_prev) begin
                    subq.delete();
                    m_have = 1'b0;
                end
                subq.push_back(int'(d) >> (12 - sw));
                if (subq.size() == bc) begin
                    w = 0;
                    foreach (subq[k]) w = (w << sw) | subq[k];
                    subq.delete();
                    if (!m_have) begin
                        m_ihold = 12'(w);
                        m_have  = 1'b1;
                    end else begin
                        e_i    = m_ihold;
                        e_q    = 12'(w);
                        e_v    = 1'b1;
                        m_have = 1'b0;
                    end
                end
            end else begin
                subq.delete();
                m_have = 1'b0;
            end
        end else begin
            if (s) begin
                m_ihold = d;
                m_have  = 1'b1;
            end else if (m_have) begin
                e_i    = m_ihold;
                e_q    = d;
                e_v    = 1'b1;
                m_have = 1'b0;
            end
        end
        m_prev = s;
    endtask

    task automatic beat(input logic s, input logic [11:0] d);
        strobe   = s;
        bus_data = d;
        model_step(s, d);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic rbeat(input logic s);
        beat(s, 12'($urandom));
    endtask

    task automatic do_reset(input logic [1:0] w, input logic c);
        rst_n          = 1'b0;
        strobe         = 1'b0;
        bus_data       = 12'h000;
        cfg_width      = w;
        cfg_continuous = c;
        repeat (3) @(negedge clk);
        m_prev = 1'b0; m_have = 1'b0; m_ihold = '0;
        e_v = 1'b0; e_i = '0; e_q = '0;
        subq.delete();
        tag = "R1";
        compare_all();
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        do_reset(2'b00, 1'b0);

        tag = "R2";
        for (int n = 0; n < 6; n++) rbeat(1'b1);
        beat(1'b1, 12'hABC);
        tag = "R9";
        for (int n = 0; n < 3; n++) rbeat(1'b0);
        tag = "R2";
        beat(1'b1, 12'h123); beat(1'b1, 12'hFED); rbeat(1'b0);

        tag = "R5";
        for (int n = 0; n < 3; n++) rbeat(1'b1);
        rbeat(1'b0);
        for (int n = 0; n < 2; n++) rbeat(1'b1);
        rbeat(1'b0); rbeat(1'b0);

        do_reset(2'b01, 1'b0);
        tag = "R3";
        beat(1'b1, 12'b101010_111111); beat(1'b1, 12'b010101_000000);
        beat(1'b1, 12'b111000_101010); beat(1'b1, 12'b000111_010101);
        for (int n = 0; n < 8; n++) rbeat(1'b1);
        rbeat(1'b0);

        tag = "R6";
        for (int n = 0; n < 3; n++) rbeat(1'b1);
        rbeat(1'b0);
        for (int n = 0; n < 5; n++) rbeat(1'b1);
        rbeat(1'b0);

        do_reset(2'b10, 1'b0);
        tag = "R4";
        for (int n = 0; n < 16; n++) rbeat(1'b1);
        rbeat(1'b0);
        tag = "R6";
        for (int n = 0; n < 6; n++) rbeat(1'b1);
        rbeat(1'b0);
        for (int n = 0; n < 8; n++) rbeat(1'b1);
        rbeat(1'b0);

        do_reset(2'b11, 1'b0);
        tag = "R10";
        for (int n = 0; n < 5; n++) rbeat(1'b1);
        rbeat(1'b0);

        do_reset(2'b00, 1'b1);
        tag = "R7";
        rbeat(1'b0); rbeat(1'b0);
        for (int n = 0; n < 4; n++) begin rbeat(1'b1); rbeat(1'b0); end
        rbeat(1'b1); rbeat(1'b1); rbeat(1'b1); rbeat(1'b0);
        rbeat(1'b0); rbeat(1'b0); rbeat(1'b1); rbeat(1'b0);

        do_reset(2'b01, 1'b1);
        tag = "R8";
        for (int n = 0; n < 4; n++) rbeat(1'b1);
        rbeat(1'b0);
        rbeat(1'b1); rbeat(1'b0); rbeat(1'b1); rbeat(1'b0);

        do_reset(2'b10, 1'b1);
        tag = "R8";
        for (int n = 0; n < 8; n++) rbeat(1'b1);
        rbeat(1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule